// File: doc/BRIEF.md
# Center-Aligned Pulse Width Modulator

This block makes the gate drive signal for the switch of a step-down DC-DC converter. A single counter forms a triangular carrier: it climbs one step per clock from zero to a top value and then falls one step per clock back to zero. A magnitude comparator sets the output high while the count is below the duty command. Because the carrier is symmetric, each pulse is centred on the counter's zero point rather than starting at the beginning of the period.

The duty command comes from a feedback regulator. It is copied into a shadow register only on the clock edge at which the counter enters zero. A command that changes part-way through a period therefore cannot cut a pulse short or split it in two. A one-clock strobe marks every zero point, which gives the regulator a fixed moment to sample its error once per period. The top value `TOP`, together with the clock rate, sets the switching frequency: one period is `2*TOP` clocks.

Top module: `cpwm_center`

## Requirements
- R1: The carrier moves by exactly one per clock, rising from 0 to `TOP`, then falling from `TOP` to 0, then rising again without a pause at either end.
- R2: Successive zero points of the carrier, and so successive strobes, are exactly `2*TOP` clocks apart.
- R3: For a registered duty `d` with 1 <= d <= TOP-1, `pwm_o` is high exactly while the count is below `d`. That gives 2*d-1 high clocks per period, centred on the zero point.
- R4: A registered duty of 0 keeps `pwm_o` low for the whole period.
- R5: A registered duty at or above `TOP` keeps `pwm_o` high for the whole period.
- R6: `duty_i` is sampled only on the clock edge at which the carrier enters zero. A change at any other time has no effect on `pwm_o` until the next period starts.
- R7: `period_stb_o` is high for one clock at each carrier zero point. That clock is also the first clock in which a newly sampled duty drives `pwm_o`.
- R8: While `rst_ni` is low, the carrier is held at 0 counting up and `pwm_o`, `period_stb_o` and the shadow duty are 0. The release is synchronised over two clocks, so counting starts on the third rising edge after release. The first period runs with the shadow duty of 0, so its output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duty_i | input | CNT_W | Duty command from the regulator, in carrier counts |
| pwm_o | output | 1 | Gate drive output, registered |
| period_stb_o | output | 1 | One-clock strobe at each carrier zero point |

## Verification
Two events share the same clock edge: the shadow register captures the duty command, and the zero-point strobe is issued. The comparator must already use the new value in that cycle. The bench provokes this case by changing `duty_i` on the very last clock before a zero point. The pulse of the period that follows must then have the width of the new command. The opposite case is also driven: a change placed mid-period must leave the current pulse at the width of the old command.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cpwm_dir_e;
endpackage

// File: rtl/cpwm_rst_sync.sv
module cpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_n[g] = 1'b1;
      end else begin : g_rest
        assign sync_n[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_n;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TOP   = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_n_o,
  output cpwm_dir_e        dir_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TopVal = CNT_W'(TOP);
  localparam logic [CNT_W-1:0] One    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  cpwm_dir_e        dir_q, dir_n;
  logic             run_en;

  assign run_en = 1'b1;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    if (dir_q == DIR_UP) begin
      cnt_n = cnt_q + One;
      if (cnt_q + One == TopVal) dir_n = DIR_DOWN;
    end else begin
      cnt_n = cnt_q - One;
      if (cnt_q == One) dir_n = DIR_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (run_en) begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign cnt_q_o = cnt_q;
  assign cnt_n_o = cnt_n;
  assign dir_o   = dir_q;
  assign wrap_o  = (cnt_n == '0);
endmodule

// File: rtl/cpwm_shadow_cmp.sv
module cpwm_shadow_cmp #(
  parameter int CNT_W = 8,
  parameter int TOP   = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] cnt_n_i,
  input  logic             wrap_i,
  output logic [CNT_W-1:0] duty_q_o,
  output logic             pwm_o,
  output logic             stb_o
);
  localparam logic [CNT_W-1:0] TopVal = CNT_W'(TOP);

  logic [CNT_W-1:0] duty_q, duty_eff;
  logic             load_en;
  logic             pwm_q, pwm_n;
  logic             stb_q;

  assign load_en  = wrap_i;
  assign duty_eff = load_en ? duty_i : duty_q;

  always_comb begin
    if (duty_eff == '0)          pwm_n = 1'b0;
    else if (duty_eff >= TopVal) pwm_n = 1'b1;
    else                         pwm_n = (cnt_n_i < duty_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
    end else if (load_en) begin
      duty_q <= duty_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      pwm_q <= pwm_n;
      stb_q <= wrap_i;
    end
  end

  assign duty_q_o = duty_q;
  assign pwm_o    = pwm_q;
  assign stb_o    = stb_q;
endmodule

// File: rtl/cpwm_center.sv
module cpwm_center
  import cpwm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TOP         = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             period_stb_o
);
  localparam bit TopFits = (TOP >= 1) && (TOP < (1 << CNT_W));

  initial begin
    if (!TopFits) $error("cpwm_center: TOP does not fit CNT_W");
  end

  logic             rst_sync;
  logic [CNT_W-1:0] cnt_q, cnt_n, duty_q;
  cpwm_dir_e        dir_q;
  logic             wrap;

  cpwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync)
  );

  cpwm_carrier #(.CNT_W(CNT_W), .TOP(TOP)) u_carrier (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync),
    .cnt_q_o (cnt_q),
    .cnt_n_o (cnt_n),
    .dir_o   (dir_q),
    .wrap_o  (wrap)
  );

  cpwm_shadow_cmp #(.CNT_W(CNT_W), .TOP(TOP)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync),
    .duty_i   (duty_i),
    .cnt_n_i  (cnt_n),
    .wrap_i   (wrap),
    .duty_q_o (duty_q),
    .pwm_o    (pwm_o),
    .stb_o    (period_stb_o)
  );
endmodule

// File: rtl/cpwm_center_chk.sv
module cpwm_center_chk
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TOP   = 200
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input cpwm_dir_e        dir_i,
  input logic [CNT_W-1:0] duty_q_i,
  input logic             pwm_i,
  input logic             stb_i
);
  localparam logic [CNT_W-1:0] TopVal = CNT_W'(TOP);

  a_r1_rise_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == DIR_UP && cnt_i < TopVal) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

  a_r1_top_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == TopVal) |=> (cnt_i == TopVal - CNT_W'(1)));

  a_r1_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= TopVal);

  a_r4_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q_i == '0) |-> !pwm_i);

  a_r5_full_duty_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q_i >= TopVal) |-> pwm_i);

  a_r6_shadow_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> $stable(duty_q_i));

  a_r7_stb_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> (cnt_i == '0));

  a_r7_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> !stb_i);
endmodule

bind cpwm_center cpwm_center_chk #(.CNT_W(CNT_W), .TOP(TOP)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_sync),
  .cnt_i    (cnt_q),
  .dir_i    (dir_q),
  .duty_q_i (duty_q),
  .pwm_i    (pwm_o),
  .stb_i    (period_stb_o)
);

// File: tb/cpwm_center_test.sv
module cpwm_center_test;
  localparam int W   = 4;
  localparam int TOP = 10;
  localparam int PER = 2 * TOP;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [W-1:0] duty = '0;
  logic         pwm, stb;

  int errors = 0;
  int checks = 0;
  bit chk_on = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_up = 1;
  int m_duty = 0;
  bit m_pwm = 0;
  bit m_stb = 0;
  int m_rel = 0;

  always #10 clk = ~clk;

  cpwm_center #(.CNT_W(W), .TOP(TOP), .SYNC_STAGES(2)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .duty_i       (duty),
    .pwm_o        (pwm),
    .period_stb_o (stb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: triangle carrier, capture at zero, compare
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_duty = 0; m_pwm = 0; m_stb = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      if (m_up) begin
        m_cnt++;
        if (m_cnt == TOP) m_up = 0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_up = 1;
      end
      m_stb = (m_cnt == 0);
      if (m_stb) m_duty = int'(duty);
      if (m_duty == 0)        m_pwm = 0;
      else if (m_duty >= TOP) m_pwm = 1;
      else                    m_pwm = (m_cnt < m_duty);
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check("R1/R3 pwm vs model", int'(pwm), int'(m_pwm));
      check("R7 strobe vs model", int'(stb), int'(m_stb));
    end
  end

  task automatic measure(output int hi, output int len);
    do @(negedge clk); while (!stb);
    hi = 0; len = 0;
    do begin
      if (pwm) hi++;
      len++;
      @(negedge clk);
    end while (!stb);
  endtask

  task automatic width_case(input int d, input string req);
    int hi, len, exp;
    @(negedge clk);
    duty = W'(d);
    measure(hi, len);
    exp = (d == 0) ? 0 : (d >= TOP) ? PER : 2 * d - 1;
    check(req, hi, exp);
    check("R2 period length", len, PER);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int hi, len;
    #1 rst_n = 1'b0;
    duty = W'(13);
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 pwm in reset", int'(pwm), 0);
    check("R8 strobe in reset", int'(stb), 0);
    chk_on = 1;
    rst_n = 1'b1;
    // R8: first period uses shadow duty 0, no strobe until first zero point
    hi = 0; len = 0;
    while (!stb && len < 4 * PER) begin
      if (pwm) hi++;
      len++;
      @(negedge clk);
    end
    check("R8 first period low", hi, 0);
    check("R8 start delay to first zero", len, PER + 2);

    width_case(4, "R3 duty 4");
    width_case(1, "R3 duty 1");
    width_case(TOP - 1, "R3 duty TOP-1");
    width_case(0, "R4 duty 0");
    width_case(TOP, "R5 duty TOP");
    width_case(15, "R5 duty max code");
    width_case(6, "R3 duty 6");

    // R6: mid-period change keeps the current pulse width
    @(negedge clk); duty = W'(3);
    do @(negedge clk); while (!stb);
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      if (i == 5) duty = W'(8);
      if (pwm) hi++;
      @(negedge clk);
    end
    check("R6 mid-period change ignored", hi, 5);
    check("R7 strobe after full period", int'(stb), 1);
    measure(hi, len);
    check("R6 new duty next period", hi, 15);

    // R7: change on the last clock before a zero point is taken at once
    do @(negedge clk); while (!stb);
    repeat (PER - 1) @(negedge clk);
    check("R7 last clock before zero", int'(stb), 0);
    duty = W'(2);
    @(negedge clk);
    check("R7 strobe on capture clock", int'(stb), 1);
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      if (pwm) hi++;
      @(negedge clk);
    end
    check("R7 same-cycle capture width", hi, 3);

    // R8: reset mid-run forces output low
    duty = W'(15);
    repeat (2 * PER) @(negedge clk);
    check("R5 high before reset", int'(pwm), 1);
    rst_n = 1'b0;
    #1;
    check("R8 async reset clears pwm", int'(pwm), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule